// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the 16x oversampling strobe for a serial port from a fast peripheral clock. The divisor is a 16-bit fixed-point number. Its upper twelve bits are the whole part and its lower four bits are a fraction in sixteenths. The output strobe lasts one clock, and shift and sample logic uses it as a clock enable. Over any long stretch, the strobe fires sixteen times per divisor worth of clocks. The serial bit rate is therefore the input clock divided by sixteen times the divisor.

The fractional part does not round. A remainder accumulator, kept in sixteenth-clock units, adds 16 each clock. When the sum reaches the divisor, it subtracts the divisor and keeps the leftover. This makes ratios such as 468.75 (value 0x1D4C), 234.375 (0x0EA6), 19.5 (0x0138) or 2.4375 (0x0027) exact on average, with ticks spaced by whole clocks that differ by at most one.

A divisor with a zero whole part parks the generator. Any divisor write restarts the accumulator, so a new rate starts from a clean phase. The reset is asserted asynchronously, active low, and released through a two-stage synchronizer.

Top module: `baud_tick_gen`

## Requirements
- R1: A one-clock pulse on `div_we` loads `div_wdata` into the divisor. The divisor value D is read as integer part `div_wdata[15:4]` plus fraction `div_wdata[3:0]`/16, so D counts sixteenths of a clock.
- R2: In the M clocks that follow a divisor write, with D at least 16, the number of ticks is floor(16·M/D).
- R3: Tick placement is exact. Count the clock edges after the write edge as steps k = 1, 2, ... The tick is high just after step k exactly when floor(16·k/D) > floor(16·(k−1)/D). The remainder carries forward and is never discarded.
- R4: With D = 16 (divisor 1.0, the fastest setting) the tick is high on every clock, starting one clock after the write.
- R5: If `div_wdata[15:4]` is zero, no tick is ever produced, whatever the fraction bits hold.
- R6: A divisor write forces the tick low on the clock after the write edge and restarts the accumulator from zero.
- R7: With D of 32 or more, two ticks never occur on adjacent clocks.
- R8: After reset, the divisor is zero and the tick is low. Reset release takes effect through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_we | input | 1 | Divisor write strobe |
| div_wdata | input | 16 | Divisor value, 12.4 fixed point |
| tick | output | 1 | 16x oversampling clock enable, one cycle wide |

## Verification
The clocked properties assume that `div_we` is a clean synchronous pulse. They also assume that no write lands in the first cycles after reset release, before the synchronizer has settled. The bench holds off all writes for several clocks after reset and drives every write as a single-cycle strobe at the falling edge. The accumulator bound and the no-adjacent-tick property also assume that the stored divisor stays constant between writes. This holds because the divisor can change only through the strobe.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  localparam int INT_W  = 12;
  localparam int FRAC_W = 4;
  localparam int DIV_W  = INT_W + FRAC_W;
  localparam int ACC_W  = DIV_W + 1;
  localparam int STEP   = 1 << FRAC_W;

  typedef logic [DIV_W-1:0] div_t;
  typedef logic [ACC_W-1:0] acc_t;
endpackage

// File: rtl/baud_rst_sync.sv
module baud_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/baud_div_reg.sv
module baud_div_reg
  import baud_tick_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  div_t wr_data,
  output div_t div_q,
  output logic active
);
  div_t div_d;

  always_comb begin
    div_d = div_q;
    if (wr_en) div_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     div_q <= '0;
    else if (wr_en) div_q <= div_d;
  end

  assign active = |div_q[DIV_W-1:FRAC_W];

  // R1: a write is reflected in the stored divisor on the next clock
  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (div_q == $past(wr_data)));
endmodule

// File: rtl/baud_frac_accum.sv
module baud_frac_accum
  import baud_tick_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  input  div_t div_val,
  output logic fire
);
  acc_t acc_q, acc_d, acc_sum, div_ext;
  logic acc_en;

  assign div_ext = {1'b0, div_val};
  assign acc_sum = acc_q + acc_t'(STEP);

  always_comb begin
    fire   = 1'b0;
    acc_d  = acc_q;
    acc_en = 1'b0;
    if (restart) begin
      acc_d  = '0;
      acc_en = 1'b1;
    end else if (active) begin
      acc_en = 1'b1;
      if (acc_sum >= div_ext) begin
        fire  = 1'b1;
        acc_d = acc_sum - div_ext;
      end else begin
        acc_d = acc_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  // R6: a restart empties the remainder
  assert_restart_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (acc_q == '0));

  // R3: the carried remainder stays below the divisor while running
  assert_acc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !restart) |=> (acc_q < div_ext));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  output logic             tick
);
  logic rst_n_s;
  div_t div_q;
  logic active;
  logic fire;
  logic tick_d;

  baud_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  baud_div_reg u_div (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (div_we),
    .wr_data (div_wdata),
    .div_q   (div_q),
    .active  (active)
  );

  baud_frac_accum u_acc (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .restart (div_we),
    .active  (active),
    .div_val (div_q),
    .fire    (fire)
  );

  always_comb tick_d = fire & ~div_we;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) tick <= 1'b0;
    else          tick <= tick_d;
  end

  // R5: a zero whole part keeps the output quiet
  assert_parked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (div_q[DIV_W-1:FRAC_W] == '0) |=> !tick);

  // R6: the clock after a write carries no tick
  assert_write_blanks_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    div_we |=> !tick);

  // R4: unit divisor ticks on every clock
  assert_unit_rate_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (div_q == div_t'(STEP) && !div_we) |=> tick);

  // R7: slow divisors never give adjacent ticks
  assert_no_adjacent_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (div_q >= div_t'(2*STEP) && tick) |=> !tick);
endmodule

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 15000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div_we = 1'b0;
  logic [15:0] div_wdata = '0;
  logic tick;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_tick_gen u_baud_tick_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_we    (div_we),
    .div_wdata (div_wdata),
    .tick      (tick)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // issue a write; returns at the falling edge right after the write edge
  task automatic write_div(input logic [15:0] v);
    @(negedge clk);
    div_we = 1'b1;
    div_wdata = v;
    @(negedge clk);
    div_we = 1'b0;
  endtask

  // R2, R3, R6: run M steps after a write, check placement and count
  task automatic run_window(input logic [15:0] d, input int m);
    longint cnt = 0;
    int mism = 0;
    longint first_bad = -1;
    write_div(d);
    check("R6 tick low after write", tick, 0);
    for (int k = 1; k <= m; k++) begin
      longint exp_t;
      @(negedge clk);
      exp_t = ((longint'(16)*k)/d > (longint'(16)*(k-1))/d) ? 1 : 0;
      if (tick !== exp_t[0]) begin
        if (mism == 0) first_bad = k;
        mism++;
      end
      cnt += tick;
    end
    if (mism != 0) $display("  placement mismatch for d=%0d first at step %0d", d, first_bad);
    check("R3 placement mismatches", mism, 0);
    check("R2 tick count", cnt, (longint'(16)*m)/d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 tick low after reset", tick, 0);

    // R5: parked after reset (divisor zero)
    begin
      int c = 0;
      for (int i = 0; i < 50; i++) begin @(negedge clk); c += tick; end
      check("R5 idle after reset", c, 0);
    end

    // R4: unit divisor
    write_div(16'h0010);
    check("R6 first cycle after write", tick, 0);
    begin
      int c = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); c += tick; end
      check("R4 every clock ticks", c, 40);
    end

    // R7: divisor 2.0 alternates
    write_div(16'h0020);
    begin
      int adj = 0;
      int c = 0;
      logic prev = 1'b0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (prev && tick) adj++;
        prev = tick;
        c += tick;
      end
      check("R7 adjacent ticks", adj, 0);
      check("R2 count at 2.0", c, 30);
    end

    // R1, R2, R3: fractional divisors
    run_window(16'h1D4C, WIN);   // 468.75
    run_window(16'h0EA6, WIN);   // 234.375
    run_window(16'h0138, WIN);   // 19.5
    run_window(16'h0027, 4000);  // 2.4375
    run_window(16'h0018, 3000);  // 1.5
    run_window(16'h0011, 3000);  // 1.0625
    run_window(16'h0FFF, WIN);   // 255.9375

    // R6: rewrite mid-stream restarts the phase
    write_div(16'h0018);
    repeat (7) @(negedge clk);
    run_window(16'h0028, 2000);

    // R5: zero whole part with nonzero fraction
    write_div(16'h000F);
    begin
      int c = 0;
      for (int i = 0; i < 300; i++) begin @(negedge clk); c += tick; end
      check("R5 fraction-only divisor silent", c, 0);
    end

    // R8: reset in the middle of running
    write_div(16'h0010);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 tick cleared by reset", tick, 0);
    rst_n = 1'b1;
    begin
      int c = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); c += tick; end
      check("R8 divisor cleared by reset", c, 0);
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule